// File: doc/BRIEF.md
# Message Buffer Partition Controller

This block keeps the partition settings for a pool of up to 128 message buffers in a time-triggered bus controller. Three consecutive groups are defined. A static group starts at index 0. A flexible group follows, and each of its buffers can be assigned to the static or the dynamic segment. A receive-FIFO group comes last. Any index above the last configured buffer is unused. For any buffer index the block answers with a class and two flags: one for buffers reserved for sync or startup traffic, and one for FIFO membership.

Settings arrive through a single register write port. Each write is judged against the protocol state presented in the same cycle. The block also decides whether a buffer may be reconfigured now, from three inputs: the protocol state, the buffer's group and a segment-lock setting. A granted reconfiguration of a flexible buffer changes the class that lookups report for it. The number of usable buffers depends on the configured payload length, because the shared buffer memory is fixed in size.

Top module: `msgbuf_partition`

## Requirements
- R1: A lookup accepted on `lk_valid` is answered exactly one cycle later on `lk_out_valid`. The class is encoded 0 static, 1 dynamic, 2 FIFO, 3 unused. Rules: index > last is unused; index < first-dynamic is static; index < first-FIFO is flexible and reports the segment it is assigned to; any other index is FIFO.
- R2: After reset, first-dynamic = 1, first-FIFO = 1, last = 0, split and lock are 0, and all node bits and the payload are 0. Buffer 0 is therefore static, buffer 1 is unused, nothing is reserved and `wr_err` is 0.
- R3: Protocol-state code 0 is the default-config state and code 1 is the config state. A write made in any other state (codes 2 to 7) changes nothing, and `wr_err` goes high for one cycle on the cycle after the write.
- R4: A partition write (`wr_sel`=0) uses these fields: first-dynamic in [6:0], first-FIFO in [13:7], last in [20:14], split in [21] and lock in [22]. The write is rejected with `wr_err` unless first-dynamic ≤ first-FIFO ≤ last+1.
- R5: Capacity is min(128, 2048 / (4 + payload words)). A partition write is rejected with `wr_err` when last+1 exceeds the capacity for the current payload.
- R6: A node write (`wr_sel`=1) uses these bits: send-startup in [0], send-sync in [1], single-slot in [2] and payload words in [9:3]. It follows the state rule of R3. It is rejected with `wr_err` when the current last+1 would exceed the capacity for the new payload.
- R7: Buffer 0 reports reserved when any of the three node bits is 1.
- R8: When split is 1 and buffer 0 is reserved, buffer 1 also reports reserved.
- R9: A reconfiguration of a reserved buffer is granted only in state 0 or 1. The answer appears one cycle after `rc_valid`, with `rc_done` high and `rc_grant` carrying the decision.
- R10: A flexible-group buffer can be reassigned (`rc_to_static` 1 = static) in the config states. In any other state this is granted only when lock is 0. A granted reassignment changes the class that later lookups report.
- R11: A static-group buffer that is not reserved grants only requests to the static segment, in any state. FIFO and unused buffers are always denied.
- R12: An accepted partition write returns every flexible buffer to the dynamic segment. A reconfiguration in the same cycle is denied and has no effect.
- R13: `lk_fifo` is 1 exactly when the reported class is FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_state | input | 3 | Protocol state code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 partition register, 1 node register |
| wr_data | input | 23 | Write data |
| wr_err | output | 1 | Pulse for a rejected write |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | 7 | Buffer index to classify |
| lk_out_valid | output | 1 | Lookup answer valid |
| lk_class | output | 2 | Buffer class |
| lk_reserved | output | 1 | Buffer is reserved for sync/startup |
| lk_fifo | output | 1 | Buffer belongs to the receive FIFO |
| rc_valid | input | 1 | Reconfiguration request |
| rc_idx | input | 7 | Buffer to reconfigure |
| rc_to_static | input | 1 | Target segment, 1 static, 0 dynamic |
| rc_done | output | 1 | Reconfiguration answer valid |
| rc_grant | output | 1 | Reconfiguration granted |

## Verification
A partition write and a reconfiguration request can arrive in the same cycle. The write clears every flexible assignment, while the request tries to set one. The bench forces this by raising `wr_en` and `rc_valid` at the same falling edge while in the config state. It then requires three things: `wr_err` low, `rc_done` high with `rc_grant` low, and a follow-up lookup that shows the targeted buffer still in the dynamic segment.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    localparam int          NBUF      = 128;
    localparam int          IDX_W     = $clog2(NBUF);
    localparam int          PL_W      = 7;
    localparam int unsigned RAM_WORDS = 2048;
    localparam int unsigned HDR_WORDS = 4;
    localparam int          WR_W      = 3 * IDX_W + 2;

    typedef enum logic [2:0] {
        PS_DEFCFG  = 3'd0,
        PS_CFG     = 3'd1,
        PS_READY   = 3'd2,
        PS_WAKE    = 3'd3,
        PS_START   = 3'd4,
        PS_RUN     = 3'd5,
        PS_PASSIVE = 3'd6,
        PS_HALT    = 3'd7
    } proto_e;

    typedef enum logic [1:0] {
        CLS_STATIC  = 2'd0,
        CLS_DYNAMIC = 2'd1,
        CLS_FIFO    = 2'd2,
        CLS_UNUSED  = 2'd3
    } bufcls_e;

    typedef enum logic [1:0] {
        GRP_FIXED = 2'd0,
        GRP_FLEX  = 2'd1,
        GRP_FIFO  = 2'd2,
        GRP_NONE  = 2'd3
    } bufgrp_e;

    typedef struct packed {
        logic             seg_lock;
        logic             split;
        logic [IDX_W-1:0] last_cfg;
        logic [IDX_W-1:0] first_fifo;
        logic [IDX_W-1:0] first_dyn;
    } part_t;

    typedef struct packed {
        logic [PL_W-1:0] pl_words;
        logic            single_slot;
        logic            tx_sync;
        logic            tx_startup;
    } node_t;

    localparam int NODE_W = $bits(node_t);

    function automatic logic cfg_state(input logic [2:0] st);
        return (st == PS_DEFCFG) || (st == PS_CFG);
    endfunction

    // Buffers that fit into the shared memory for a given payload length.
    function automatic logic [IDX_W:0] buf_capacity(input logic [PL_W-1:0] pl);
        int unsigned q;
        q = RAM_WORDS / (HDR_WORDS + 32'(pl));
        if (q > NBUF) q = NBUF;
        return q[IDX_W:0];
    endfunction

    function automatic logic layout_ordered(input part_t p);
        return (p.first_dyn <= p.first_fifo) &&
               ({1'b0, p.first_fifo} <= ({1'b0, p.last_cfg} + 1'b1));
    endfunction

    function automatic logic layout_fits(input logic [IDX_W-1:0] last,
                                         input logic [IDX_W:0]   cap);
        return ({1'b0, last} + 1'b1) <= cap;
    endfunction

    function automatic bufgrp_e group_of(input part_t p, input logic [IDX_W-1:0] idx);
        if (idx > p.last_cfg)        return GRP_NONE;
        else if (idx < p.first_dyn)  return GRP_FIXED;
        else if (idx < p.first_fifo) return GRP_FLEX;
        else                         return GRP_FIFO;
    endfunction

endpackage

// File: rtl/mbp_regs.sv
module mbp_regs
    import mbp_pkg::*;
#(
    parameter int W = WR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   proto_state,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output part_t        part,
    output node_t        node,
    output logic         part_take,
    output logic         wr_err
);

    part_t new_part;
    node_t new_node;
    logic  state_ok;
    logic  node_take;

    always_comb begin
        new_part  = part_t'(wr_data[$bits(part_t)-1:0]);
        new_node  = node_t'(wr_data[NODE_W-1:0]);
        state_ok  = cfg_state(proto_state);
        part_take = wr_en && !wr_sel && state_ok &&
                    layout_ordered(new_part) &&
                    layout_fits(new_part.last_cfg, buf_capacity(node.pl_words));
        node_take = wr_en && wr_sel && state_ok &&
                    layout_fits(part.last_cfg, buf_capacity(new_node.pl_words));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part.first_dyn  <= IDX_W'(1);
            part.first_fifo <= IDX_W'(1);
            part.last_cfg   <= '0;
            part.split      <= 1'b0;
            part.seg_lock   <= 1'b0;
            node            <= '0;
            wr_err          <= 1'b0;
        end else begin
            if (part_take) part <= new_part;
            if (node_take) node <= new_node;
            wr_err <= wr_en && !(part_take || node_take);
        end
    end

endmodule

// File: rtl/mbp_classify.sv
module mbp_classify
    import mbp_pkg::*;
#(
    parameter int N  = NBUF,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  part_t         part,
    input  logic [N-1:0]  seg_static,
    input  logic          rsv0,
    input  logic          rsv1,
    input  logic          lk_valid,
    input  logic [IW-1:0] lk_idx,
    output logic          lk_out_valid,
    output logic [1:0]    lk_class,
    output logic          lk_reserved,
    output logic          lk_fifo
);

    bufcls_e cls_c;
    logic    rsv_c;

    always_comb begin
        unique case (group_of(part, lk_idx))
            GRP_FIXED: cls_c = CLS_STATIC;
            GRP_FLEX:  cls_c = seg_static[lk_idx] ? CLS_STATIC : CLS_DYNAMIC;
            GRP_FIFO:  cls_c = CLS_FIFO;
            default:   cls_c = CLS_UNUSED;
        endcase
        rsv_c = ((lk_idx == IW'(0)) && rsv0) || ((lk_idx == IW'(1)) && rsv1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_out_valid <= 1'b0;
            lk_class     <= CLS_UNUSED;
            lk_reserved  <= 1'b0;
            lk_fifo      <= 1'b0;
        end else begin
            lk_out_valid <= lk_valid;
            if (lk_valid) begin
                lk_class    <= cls_c;
                lk_reserved <= rsv_c;
                lk_fifo     <= (group_of(part, lk_idx) == GRP_FIFO);
            end
        end
    end

endmodule

// File: rtl/mbp_reconf.sv
module mbp_reconf
    import mbp_pkg::*;
#(
    parameter int N  = NBUF,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    proto_state,
    input  part_t         part,
    input  logic          rsv0,
    input  logic          rsv1,
    input  logic          part_take,
    input  logic          rc_valid,
    input  logic [IW-1:0] rc_idx,
    input  logic          rc_to_static,
    output logic [N-1:0]  seg_static,
    output logic          rc_done,
    output logic          rc_grant
);

    bufgrp_e grp;
    logic    is_rsv;
    logic    allow;
    logic    in_cfg;

    always_comb begin
        grp    = group_of(part, rc_idx);
        in_cfg = cfg_state(proto_state);
        is_rsv = ((rc_idx == IW'(0)) && rsv0) || ((rc_idx == IW'(1)) && rsv1);
        if (part_take)              allow = 1'b0;
        else if (grp == GRP_NONE)   allow = 1'b0;
        else if (is_rsv)            allow = in_cfg;
        else if (grp == GRP_FIXED)  allow = rc_to_static;
        else if (grp == GRP_FLEX)   allow = in_cfg || !part.seg_lock;
        else                        allow = 1'b0;
    end

    for (genvar b = 0; b < N; b++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst || part_take)
                seg_static[b] <= 1'b0;
            else if (rc_valid && allow && (grp == GRP_FLEX) && (rc_idx == IW'(b)))
                seg_static[b] <= rc_to_static;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_done  <= 1'b0;
            rc_grant <= 1'b0;
        end else begin
            rc_done  <= rc_valid;
            rc_grant <= rc_valid && allow;
        end
    end

endmodule

// File: rtl/msgbuf_partition.sv
module msgbuf_partition
    import mbp_pkg::*;
#(
    parameter int N  = NBUF,
    parameter int IW = IDX_W,
    parameter int DW = WR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    proto_state,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          wr_err,
    input  logic          lk_valid,
    input  logic [IW-1:0] lk_idx,
    output logic          lk_out_valid,
    output logic [1:0]    lk_class,
    output logic          lk_reserved,
    output logic          lk_fifo,
    input  logic          rc_valid,
    input  logic [IW-1:0] rc_idx,
    input  logic          rc_to_static,
    output logic          rc_done,
    output logic          rc_grant
);

    part_t        part;
    node_t        node;
    logic         part_take;
    logic [N-1:0] seg_static;
    logic         rsv_buf0;
    logic         rsv_buf1;

    assign rsv_buf0 = node.tx_startup || node.tx_sync || node.single_slot;
    assign rsv_buf1 = rsv_buf0 && part.split;

    mbp_regs #(.W(DW)) u_regs (
        .clk(clk), .rst(rst), .proto_state(proto_state),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .part(part), .node(node), .part_take(part_take), .wr_err(wr_err)
    );

    mbp_classify #(.N(N), .IW(IW)) u_cls (
        .clk(clk), .rst(rst), .part(part), .seg_static(seg_static),
        .rsv0(rsv_buf0), .rsv1(rsv_buf1),
        .lk_valid(lk_valid), .lk_idx(lk_idx),
        .lk_out_valid(lk_out_valid), .lk_class(lk_class),
        .lk_reserved(lk_reserved), .lk_fifo(lk_fifo)
    );

    mbp_reconf #(.N(N), .IW(IW)) u_rc (
        .clk(clk), .rst(rst), .proto_state(proto_state), .part(part),
        .rsv0(rsv_buf0), .rsv1(rsv_buf1), .part_take(part_take),
        .rc_valid(rc_valid), .rc_idx(rc_idx), .rc_to_static(rc_to_static),
        .seg_static(seg_static), .rc_done(rc_done), .rc_grant(rc_grant)
    );

endmodule

// File: rtl/msgbuf_partition_chk.sv
module msgbuf_partition_chk #(
    parameter int IW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    proto_state,
    input logic          wr_en,
    input logic          wr_err,
    input logic          lk_valid,
    input logic          lk_out_valid,
    input logic          rc_valid,
    input logic [IW-1:0] rc_idx,
    input logic          rc_done,
    input logic          rc_grant,
    input logic          rsv0
);

    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (rst) lk_valid |=> lk_out_valid); // R1
    AST_LK_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !lk_out_valid); // R1
    AST_RUN_WRITE_ERR: assert property (@(posedge clk) disable iff (rst) (wr_en && proto_state > 3'd1) |=> wr_err); // R3
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst) wr_err |-> $past(wr_en)); // R3
    AST_RSV_LOCKED: assert property (@(posedge clk) disable iff (rst) (rc_valid && rc_idx == '0 && rsv0 && proto_state > 3'd1) |=> (rc_done && !rc_grant)); // R9
    AST_GRANT_ANSWER: assert property (@(posedge clk) disable iff (rst) rc_grant |-> (rc_done && $past(rc_valid))); // R9

endmodule

bind msgbuf_partition msgbuf_partition_chk #(.IW(IW)) i_chk (
    .clk(clk), .rst(rst), .proto_state(proto_state),
    .wr_en(wr_en), .wr_err(wr_err),
    .lk_valid(lk_valid), .lk_out_valid(lk_out_valid),
    .rc_valid(rc_valid), .rc_idx(rc_idx),
    .rc_done(rc_done), .rc_grant(rc_grant), .rsv0(rsv_buf0)
);

// File: tb/test_msgbuf_partition.sv
module test_msgbuf_partition;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  proto_state = 3'd1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [22:0] wr_data = '0;
    logic        wr_err;
    logic        lk_valid = 1'b0;
    logic [6:0]  lk_idx = '0;
    logic        lk_out_valid;
    logic [1:0]  lk_class;
    logic        lk_reserved;
    logic        lk_fifo;
    logic        rc_valid = 1'b0;
    logic [6:0]  rc_idx = '0;
    logic        rc_to_static = 1'b0;
    logic        rc_done;
    logic        rc_grant;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    localparam logic [2:0] CFG = 3'd1;
    localparam logic [2:0] RUN = 3'd5;
    localparam int S = 0, D = 1, F = 2, U = 3;

    always #2 clk = ~clk;

    msgbuf_partition i_msgbuf_partition (.*);

    typedef struct packed {
        logic [6:0] idx;
        logic [1:0] cls;
        logic       fifo;
    } vec_t;

    localparam vec_t VEC[8] = '{
        '{7'd0,   2'd0, 1'b0}, '{7'd7,   2'd0, 1'b0},
        '{7'd8,   2'd1, 1'b0}, '{7'd39,  2'd1, 1'b0},
        '{7'd40,  2'd2, 1'b1}, '{7'd63,  2'd2, 1'b1},
        '{7'd64,  2'd3, 1'b0}, '{7'd127, 2'd3, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [22:0] mkpart(input int fd, input int ff, input int last,
                                           input bit split, input bit lock);
        return {lock, split, 7'(last), 7'(ff), 7'(fd)};
    endfunction

    function automatic logic [22:0] mknode(input int pl, input bit stup, input bit sync, input bit ss);
        return {13'd0, 7'(pl), ss, sync, stup};
    endfunction

    task automatic do_write(input logic sel, input logic [22:0] d, input logic [2:0] st,
                            output logic err);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; proto_state = st;
        @(posedge clk); #1;
        err = wr_err;
        wr_en = 1'b0;
    endtask

    task automatic do_lookup(input int idx, output int cls, output int rsv, output int fifo);
        @(negedge clk);
        lk_valid = 1'b1; lk_idx = 7'(idx);
        @(posedge clk); #1;
        cls = int'(lk_class); rsv = int'(lk_reserved); fifo = int'(lk_fifo);
        lk_valid = 1'b0;
    endtask

    task automatic do_reconf(input int idx, input bit to_st, input logic [2:0] st, output int grant);
        @(negedge clk);
        rc_valid = 1'b1; rc_idx = 7'(idx); rc_to_static = to_st; proto_state = st;
        @(posedge clk); #1;
        grant = rc_done ? int'(rc_grant) : -1;
        rc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic err;
        int cls, rsv, fifo, g;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R2", int'(wr_err), 0, "wr_err after reset");
        check("R2", int'(lk_out_valid), 0, "lk_out_valid after reset");
        do_lookup(0, cls, rsv, fifo);
        check("R2", cls, S, "buffer 0 class");
        check("R2", rsv, 0, "buffer 0 reserved");
        do_lookup(1, cls, rsv, fifo);
        check("R2", cls, U, "buffer 1 class");

        // R3 accepted layout in config state
        do_write(1'b0, mkpart(8, 40, 63, 0, 1), CFG, err);
        check("R3", int'(err), 0, "config-state write");
        foreach (VEC[i]) begin
            do_lookup(int'(VEC[i].idx), cls, rsv, fifo);
            check("R1", cls, int'(VEC[i].cls), $sformatf("class of %0d", VEC[i].idx));
            check("R13", fifo, int'(VEC[i].fifo), $sformatf("fifo flag of %0d", VEC[i].idx));
        end

        // R3 write outside config states is ignored
        do_write(1'b0, mkpart(2, 3, 5, 0, 0), RUN, err);
        check("R3", int'(err), 1, "run-state write error");
        do_lookup(8, cls, rsv, fifo);
        check("R3", cls, D, "layout unchanged after run write");

        // R4 ordering
        do_write(1'b0, mkpart(20, 10, 63, 0, 1), CFG, err);
        check("R4", int'(err), 1, "dyn above fifo");
        do_lookup(15, cls, rsv, fifo);
        check("R4", cls, D, "layout unchanged after bad order");
        do_write(1'b0, mkpart(8, 64, 63, 0, 1), CFG, err);
        check("R4", int'(err), 0, "fifo start at last+1");
        do_lookup(63, cls, rsv, fifo);
        check("R4", cls, D, "no fifo when start is last+1");
        do_write(1'b0, mkpart(8, 66, 63, 0, 1), CFG, err);
        check("R4", int'(err), 1, "fifo start beyond last+1");
        do_write(1'b0, mkpart(8, 40, 63, 0, 1), CFG, err);

        // R5 / R6 capacity against payload
        do_write(1'b1, mknode(127, 0, 0, 0), CFG, err);
        check("R6", int'(err), 1, "payload too large for 64 buffers");
        do_write(1'b0, mkpart(4, 10, 14, 0, 1), CFG, err);
        check("R5", int'(err), 0, "15 buffers at payload 0");
        do_write(1'b1, mknode(127, 0, 0, 0), CFG, err);
        check("R6", int'(err), 0, "payload 127 with 15 buffers");
        do_write(1'b0, mkpart(4, 10, 15, 0, 1), CFG, err);
        check("R5", int'(err), 1, "16 buffers exceed capacity 15");
        do_lookup(15, cls, rsv, fifo);
        check("R5", cls, U, "buffer 15 still unused");
        do_write(1'b1, mknode(0, 0, 0, 0), RUN, err);
        check("R6", int'(err), 1, "node write in run state");
        do_write(1'b0, mkpart(4, 10, 15, 0, 1), CFG, err);
        check("R6", int'(err), 1, "payload kept after run-state node write");
        do_write(1'b1, mknode(0, 0, 0, 0), CFG, err);
        check("R6", int'(err), 0, "payload back to 0");

        // R7 / R8 reserved buffers
        do_write(1'b1, mknode(0, 0, 1, 0), CFG, err);
        do_lookup(0, cls, rsv, fifo);
        check("R7", rsv, 1, "buffer 0 reserved by sync bit");
        do_lookup(1, cls, rsv, fifo);
        check("R8", rsv, 0, "buffer 1 free without split");
        do_write(1'b0, mkpart(8, 40, 63, 1, 1), CFG, err);
        do_lookup(1, cls, rsv, fifo);
        check("R8", rsv, 1, "buffer 1 reserved with split");

        // R9 reserved reconfiguration
        do_reconf(0, 1, RUN, g);
        check("R9", g, 0, "buffer 0 in run state");
        do_reconf(1, 1, RUN, g);
        check("R9", g, 0, "buffer 1 in run state");
        do_reconf(0, 1, CFG, g);
        check("R9", g, 1, "buffer 0 in config state");

        // R10 runtime flexible reassignment
        do_write(1'b0, mkpart(8, 40, 63, 1, 0), CFG, err);
        do_reconf(20, 1, RUN, g);
        check("R10", g, 1, "unlocked run-state switch");
        do_lookup(20, cls, rsv, fifo);
        check("R10", cls, S, "buffer 20 now static");
        do_lookup(21, cls, rsv, fifo);
        check("R10", cls, D, "buffer 21 untouched");
        do_write(1'b0, mkpart(8, 40, 63, 1, 1), CFG, err);
        do_lookup(20, cls, rsv, fifo);
        check("R12", cls, D, "layout write clears switch");
        do_reconf(20, 1, RUN, g);
        check("R10", g, 0, "locked run-state switch");
        do_lookup(20, cls, rsv, fifo);
        check("R10", cls, D, "denied switch has no effect");
        do_reconf(20, 1, CFG, g);
        check("R10", g, 1, "locked switch in config state");
        do_lookup(20, cls, rsv, fifo);
        check("R10", cls, S, "buffer 20 static in config");

        // R11 other groups
        do_reconf(5, 1, RUN, g);
        check("R11", g, 1, "static buffer to static");
        do_reconf(5, 0, RUN, g);
        check("R11", g, 0, "static buffer to dynamic");
        do_reconf(45, 1, CFG, g);
        check("R11", g, 0, "fifo buffer");
        do_reconf(100, 1, CFG, g);
        check("R11", g, 0, "unused buffer");

        // R12 layout write and reconfiguration in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = mkpart(8, 40, 63, 1, 1); proto_state = CFG;
        rc_valid = 1'b1; rc_idx = 7'd25; rc_to_static = 1'b1;
        @(posedge clk); #1;
        check("R12", int'(wr_err), 0, "collision write accepted");
        check("R12", int'(rc_done), 1, "collision request answered");
        check("R12", int'(rc_grant), 0, "collision request denied");
        wr_en = 1'b0; rc_valid = 1'b0;
        do_lookup(25, cls, rsv, fifo);
        check("R12", cls, D, "buffer 25 stays dynamic");
        do_lookup(20, cls, rsv, fifo);
        check("R12", cls, D, "buffer 20 cleared by write");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule